// File: doc/BRIEF.md
# Frame-Driven Chip-Select Write Sequencer

This block sits in the system clock domain between a byte FIFO that holds received frames and a 32-bit external write bus that feeds three target devices. A single-cycle start pulse tells it that one complete frame is waiting in the FIFO. From that pulse on, the block needs no further handshake. It pulls the frame's bytes one per cycle, packs them four at a time into a bus word and issues each word with a one-cycle write strobe. A divide-by-eight clock enable paces the strobes. The fixed frame length of 162 bytes is not a multiple of four, so the last word of every frame carries only two bytes, and the rest of that word is zero.

One of three chip selects is always active. A chip select does not follow frame boundaries. It stays on for a whole quota of frames (by default 128 × 512) and then hands over to the next device in a fixed circular order. If a start pulse arrives while a frame is still in progress, it does not start a second transfer. It sets a sticky overrun flag that only reset clears.

Neither data edge applies back-pressure. The source must present the next byte whenever `src_pop` is high, with the byte visible in the same cycle (show-ahead). The external devices must accept every word on the cycle its strobe is high.

Top module: `seq_frame_writer`

## Requirements
- R1: A `frame_go` pulse seen while idle starts one transfer of exactly 41 words. Each word is announced by `bus_wr` high for exactly one cycle.
- R2: Each transfer takes exactly 162 bytes from the source. One byte is consumed in every cycle `src_pop` is high, and no byte is consumed while the block is idle.
- R3: Byte j of a word (j = 0..3, in source order) appears on `bus_data[8j+7:8j]`. The final word of a frame carries bytes 160 and 161 in lanes 0 and 1, and bits 31:16 of that word are zero.
- R4: Count the rising clock edges since reset was released, with the first edge counted as 1. `bus_wr` is high only in the cycle after edge n where n is a multiple of 8, so strobes are always at least 8 cycles apart.
- R5: `dev_sel` has exactly one bit set at all times. Bit d selects device d, and after reset it equals 3'b001 (device 0).
- R6: `dev_sel` holds its value across FRAMES_PER_DEV complete frames. It changes in the cycle right after the final `bus_wr` of the last frame of that quota, and the order is device 0, then 1, then 2, then back to 0.
- R7: A `frame_go` pulse that arrives between the start of a transfer and the cycle after its last word sets `overrun` on the next cycle. `overrun` then stays high until reset. The pulse adds no words and consumes no bytes.
- R8: Reset returns `dev_sel` to device 0, clears the per-device frame count and clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_go | input | 1 | Single-cycle pulse: one full frame is ready in the source |
| src_byte | input | 8 | Show-ahead byte from the frame source |
| src_pop | output | 1 | Consume `src_byte` at this clock edge |
| bus_wr | output | 1 | Write strobe for the external bus, one cycle per word |
| bus_data | output | 32 | Packed word, valid while `bus_wr` is high |
| dev_sel | output | 3 | One-hot chip select of the current target device |
| overrun | output | 1 | Sticky flag: a start pulse arrived during a transfer |

## Verification
A fault in the byte index or in the lane counter shows up quickly. It shifts the source stream, so the first wrong word appears within about eight cycles, and every later frame is misaligned as well. A fault in the pacing divider puts a strobe on a cycle that is not on the eight-cycle grid, and the reference model flags it on that cycle. Faults in the quota counter or the device index show up only at a quota boundary, as a chip select that moves one frame too early or too late. For that reason the bench uses a small quota and runs through a full wrap of the rotation, and also through a reset in the middle of a quota.

// File: rtl/seq_frame_pkg.sv
package seq_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // width needed to hold values 0..n-1, never below one bit
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/seq_pace_div.sv
module seq_pace_div
  import seq_frame_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = cnt_w(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == CW'(DIV - 1));

  generate
    if (DIV > 1) begin : g_spacing_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/seq_word_packer.sv
module seq_word_packer
  import seq_frame_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          load,
  input  logic [cnt_w(WORD_BYTES)-1:0]  lane,
  input  logic [7:0]                    byte_in,
  output logic [8*WORD_BYTES-1:0]       word
);
  localparam int unsigned LW = cnt_w(WORD_BYTES);

  generate
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (clear) begin
          q <= '0;
        end else if (load && (lane == LW'(g))) begin
          q <= byte_in;
        end
      end
      assign word[8*g +: 8] = q;
    end
  endgenerate

endmodule

// File: rtl/seq_target_rotator.sv
module seq_target_rotator
  import seq_frame_pkg::*;
#(
  parameter int unsigned NUM_DEV        = 3,
  parameter int unsigned FRAMES_PER_DEV = 65536
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [NUM_DEV-1:0] dev_sel
);
  localparam int unsigned FW = cnt_w(FRAMES_PER_DEV);
  localparam int unsigned DW = cnt_w(NUM_DEV);

  logic [FW-1:0] frame_cnt_q;
  logic [DW-1:0] dev_idx_q;
  logic [DW-1:0] dev_idx_nx;
  logic          quota_end;

  assign quota_end  = (frame_cnt_q == FW'(FRAMES_PER_DEV - 1));
  assign dev_idx_nx = (dev_idx_q == DW'(NUM_DEV - 1)) ? '0 : dev_idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt_q <= '0;
      dev_idx_q   <= '0;
      dev_sel     <= NUM_DEV'(1);
    end else if (advance) begin
      if (quota_end) begin
        frame_cnt_q <= '0;
        dev_idx_q   <= dev_idx_nx;
        dev_sel     <= NUM_DEV'(1) << dev_idx_nx;
      end else begin
        frame_cnt_q <= frame_cnt_q + 1'b1;
      end
    end
  end

  AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_sel) == 1); // R5
  AST_SEL_MOVES_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_sel) |-> $past(advance)); // R6

endmodule

// File: rtl/seq_frame_writer.sv
module seq_frame_writer
  import seq_frame_pkg::*;
#(
  parameter int unsigned FRAME_BYTES    = 162,
  parameter int unsigned WORD_BYTES     = 4,
  parameter int unsigned BUS_DIV        = 8,
  parameter int unsigned NUM_DEV        = 3,
  parameter int unsigned FRAMES_PER_DEV = 65536
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_go,
  input  logic [7:0]              src_byte,
  output logic                    src_pop,
  output logic                    bus_wr,
  output logic [8*WORD_BYTES-1:0] bus_data,
  output logic [NUM_DEV-1:0]      dev_sel,
  output logic                    overrun
);
  localparam int unsigned WW = 8 * WORD_BYTES;
  localparam int unsigned LW = cnt_w(WORD_BYTES);
  localparam int unsigned BW = cnt_w(FRAME_BYTES + 1);

  seq_state_e    state_q;
  logic [LW-1:0] lane_q;
  logic [BW-1:0] byte_idx_q;
  logic          tick;
  logic [WW-1:0] packed_word;
  logic          pk_load;
  logic          pk_clear;
  logic          issue;
  logic          advance;
  logic          busy;
  logic          word_full;

  seq_pace_div #(.DIV(BUS_DIV)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  seq_word_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (pk_clear),
    .load   (pk_load),
    .lane   (lane_q),
    .byte_in(src_byte),
    .word   (packed_word)
  );

  seq_target_rotator #(
    .NUM_DEV       (NUM_DEV),
    .FRAMES_PER_DEV(FRAMES_PER_DEV)
  ) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(advance),
    .dev_sel(dev_sel)
  );

  assign pk_load   = (state_q == ST_FILL);
  assign src_pop   = pk_load;
  assign issue     = (state_q == ST_WAIT) && tick;
  assign pk_clear  = issue;
  assign advance   = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);
  assign word_full = (lane_q == LW'(WORD_BYTES - 1)) ||
                     (byte_idx_q == BW'(FRAME_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lane_q     <= '0;
      byte_idx_q <= '0;
      bus_wr     <= 1'b0;
      bus_data   <= '0;
    end else begin
      bus_wr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (frame_go) begin
            state_q    <= ST_FILL;
            lane_q     <= '0;
            byte_idx_q <= '0;
          end
        end
        ST_FILL: begin
          byte_idx_q <= byte_idx_q + 1'b1;
          lane_q     <= lane_q + 1'b1;
          if (word_full) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            bus_wr   <= 1'b1;
            bus_data <= packed_word;
            lane_q   <= '0;
            if (byte_idx_q == BW'(FRAME_BYTES)) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (frame_go && busy) begin
      overrun <= 1'b1;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr); // R1
  AST_STROBE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(tick)); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && busy) |=> overrun); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_NO_POP_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && !$past(frame_go)) |-> !src_pop); // R2

endmodule

// File: tb/tb_seq_frame_writer.sv
module tb_seq_frame_writer;
  localparam int CLK_PERIOD = 10;
  localparam int FB    = 162;
  localparam int WB    = 4;
  localparam int NDEV  = 3;
  localparam int FPD   = 3;
  localparam int WORDS = (FB + WB - 1) / WB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_go = 1'b0;
  logic [7:0]  src_byte = '0;
  logic        src_pop;
  logic        bus_wr;
  logic [31:0] bus_data;
  logic [2:0]  dev_sel;
  logic        overrun;

  seq_frame_writer #(
    .FRAME_BYTES(FB), .WORD_BYTES(WB), .BUS_DIV(8),
    .NUM_DEV(NDEV), .FRAMES_PER_DEV(FPD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .src_byte(src_byte),
    .src_pop(src_pop), .bus_wr(bus_wr), .bus_data(bus_data),
    .dev_sel(dev_sel), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_q[$];
  int idx = 0;
  int issued = 0;
  int n = 0;
  bit prev_pop = 1'b0;
  int dev_exp = 0;
  int fcount = 0;
  int wcount = 0;
  bit pend = 1'b0;
  bit ovr_exp = 1'b0;

  function automatic logic [7:0] byte_at(input int i);
    return 8'(i * 37 + i / 256 + 11);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model and source stream, sampled a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!rst_n) begin
        n = 0; dev_exp = 0; fcount = 0; wcount = 0; pend = 0; ovr_exp = 0;
        exp_q.delete();
        check(dev_sel == 3'b001, "R8", "dev_sel in reset", dev_sel, 1);
        check(overrun == 1'b0, "R8", "overrun in reset", overrun, 0);
        check(bus_wr == 1'b0, "R1", "bus_wr in reset", bus_wr, 0);
      end else begin
        n++;
        if (pend) begin
          dev_exp = (dev_exp + 1) % NDEV;
          pend = 0;
        end
        check($countones(dev_sel) == 1, "R5", "dev_sel one-hot", dev_sel, 3'(1 << dev_exp));
        check(dev_sel == 3'(1 << dev_exp), "R6", "dev_sel", dev_sel, 3'(1 << dev_exp));
        check(overrun == ovr_exp, "R7", "overrun", overrun, ovr_exp);
        if (bus_wr) begin
          check(n % 8 == 0, "R4", "strobe off pacing grid, edge", n, (n / 8) * 8);
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected bus_wr", 1, 0);
          end else begin
            logic [31:0] w;
            w = exp_q.pop_front();
            check(bus_data == w, "R3", "bus_data", bus_data, w);
            wcount++;
            if (wcount == WORDS) begin
              wcount = 0;
              fcount++;
              if (fcount == FPD) begin
                fcount = 0;
                pend = 1;
              end
            end
          end
        end
      end
      if (prev_pop) idx++;
      src_byte = byte_at(idx);
      prev_pop = src_pop;
    end
  end

  task automatic start_frame(input int gap, input bit expect_overrun);
    repeat (gap) @(negedge clk);
    frame_go = 1'b1;
    if (expect_overrun) begin
      ovr_exp = 1'b1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        logic [31:0] word;
        word = '0;
        for (int b = 0; b < WB; b++) begin
          if (w * WB + b < FB) word[8*b +: 8] = byte_at(issued + w * WB + b);
        end
        exp_q.push_back(word);
      end
      issued += FB;
    end
    @(negedge clk);
    frame_go = 1'b0;
  endtask

  task automatic finish_frame();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(idx == issued, "R2", "bytes consumed", idx, issued);
    check(wcount == 0, "R1", "words in frame", wcount, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R2: nothing consumed while idle
    check(idx == 0, "R2", "idle consumption", idx, 0);

    // R6: full rotation 0 -> 1 -> 2 -> 0 with varied gaps, incl. back-to-back
    for (int f = 0; f < 3 * FPD + 1; f++) begin
      start_frame(f % 3 == 0 ? 0 : 3 + 5 * f, 1'b0);
      finish_frame();
    end
    check(dev_sel == 3'b001, "R6", "dev_sel after wrap", dev_sel, 1);

    // R7: start pulse during a transfer
    start_frame(1, 1'b0);
    repeat (100) @(negedge clk);
    start_frame(0, 1'b1);
    finish_frame();
    repeat (20) @(negedge clk);
    check(overrun == 1'b1, "R7", "overrun still set", overrun, 1);
    check(idx == issued, "R7", "no bytes for dropped pulse", idx, issued);

    // R8: reset mid-quota clears count, device and flag
    do_reset();
    @(negedge clk);
    check(overrun == 1'b0, "R8", "overrun after reset", overrun, 0);
    check(dev_sel == 3'b001, "R8", "dev_sel after reset", dev_sel, 1);
    for (int f = 0; f < FPD + 1; f++) begin
      start_frame(2, 1'b0);
      finish_frame();
    end
    check(dev_sel == 3'b010, "R8", "dev_sel after fresh quota", dev_sel, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule